// File: doc/BRIEF.md
# Gated Tone Generator for LNB Supply Signalling

This block produces a square-wave tone, nominally 22 kHz at 50% duty, to be superimposed on a satellite LNB supply line by an analog stage outside this block. The tone period comes from the system clock through a divider. The divider's half-period is fixed at elaboration time as the nearest whole number of clocks to `CLK_HZ / (2 * TONE_HZ)`.

An arming input enables the output stage. Once the stage is armed, the tone can run in two ways. A continuous-enable bit runs it for as long as the bit is set. A keying input gates it burst by burst for tone-burst data signalling. Keyed bursts open half a tone period after the keying input rises and close one full tone period after it falls. A gap in the keying input that is shorter than the close delay therefore does not break the burst.

Whenever the tone is stopped, the current high half-period runs to its end, so no short pulse is produced. Disarming the stage holds the output low at once.

Top module: `tone_gate_keyer`

## Requirements
- R1: While reset is asserted and directly after it, `tone_out` and `stage_on` are 0.
- R2: `stage_on` equals the value of `tx_arm` sampled at the previous rising clock edge.
- R3: While the tone runs, `tone_out` alternates between high and low segments that are each exactly HALF clocks long, where HALF = floor((CLK_HZ + TONE_HZ) / (2*TONE_HZ)). The first segment is high.
- R4: With the stage armed and the generator idle, `cont_en` sampled at 1 on edge c sets `tone_out` high after edge c. When `cont_en` is first sampled at 0, the tone stops, subject to R10. Keying pulses of HALF clocks or fewer during continuous mode leave the waveform unchanged.
- R5: With `SYNC_STAGES`=2 and the stage armed, `key_in` first sampled at 1 on edge r starts the tone high after edge r+HALF+3, provided it stays high for more than HALF clocks.
- R6: If `key_in` is first sampled at 0 on edge f, the tone keeps running through edge f+2*HALF+2. It stops from edge f+2*HALF+3 onward, subject to R10.
- R7: A keying pulse sampled high on HALF consecutive edges or fewer produces no tone.
- R8: If `key_in` rises again no more than 2*HALF clocks after it was first sampled low, the burst continues without a break. The stop delay of R6 then counts from the last fall.
- R9: While `stage_on` is 0, `tone_out` is 0 whatever `cont_en` and `key_in` do. A continuous tone starts high one edge after `stage_on` rises.
- R10: When the tone stops while high, the high segment is completed to its full HALF clocks. When it stops while low, the output stays low. Disarming is the only exception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_arm | input | 1 | Arms the tone output stage |
| cont_en | input | 1 | Continuous tone enable (synchronous) |
| key_in | input | 1 | Asynchronous keying input for bursts |
| tone_out | output | 1 | Tone level |
| stage_on | output | 1 | Output stage is armed |

## Verification
The hardest situations to reach are the keying corners. One is a pulse one clock too short to open a burst. Another is a re-rise landing exactly on the last clock of the close delay. A third is a stop request landing in each phase of the tone. The bench sweeps the keying pulse length over every value from 1 to 4*HALF with a small divider, so each length ends the burst in a different tone phase. It repeats pairs of pulses with gaps up to the full close delay, and it sweeps the length of continuous mode. It compares every cycle against a waveform computed arithmetically from the start and stop edges.

// File: rtl/tgen_pkg.sv
package tgen_pkg;

   typedef enum logic [1:0] {
      KG_IDLE  = 2'd0,
      KG_START = 2'd1,
      KG_ON    = 2'd2,
      KG_STOP  = 2'd3
   } kg_state_t;

   // nearest whole number of clocks per half tone period
   function automatic int half_cycles(input int clk_hz, input int tone_hz);
      return (clk_hz + tone_hz) / (2 * tone_hz);
   endfunction

endpackage

// File: rtl/tgen_sync.sv
module tgen_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES == 1) begin : g_bad_depth
      $error("tgen_sync: STAGES must be 0 or at least 2");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else begin : g_chain
      logic [STAGES-1:0] ff_q;
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) ff_q[0] <= 1'b0;
               else        ff_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) ff_q[i] <= 1'b0;
               else        ff_q[i] <= ff_q[i-1];
            end
         end
      end
      assign q_o = ff_q[STAGES-1];
   end

endmodule

// File: rtl/tgen_keygate.sv
module tgen_keygate
   import tgen_pkg::*;
#(
   parameter int HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic key_s,
   output logic gate_o
);

   localparam int DW = $clog2(2 * HALF);
   localparam logic [DW-1:0] OPEN_LAST  = DW'(HALF - 1);
   localparam logic [DW-1:0] CLOSE_LAST = DW'(2 * HALF - 1);

   if (HALF < 2) begin : g_bad_half
      $error("tgen_keygate: HALF must be at least 2");
   end

   kg_state_t       state_q;
   logic [DW-1:0]   dcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= KG_IDLE;
         dcnt_q  <= '0;
      end else begin
         unique case (state_q)
            KG_IDLE: begin
               if (key_s) begin
                  state_q <= KG_START;
                  dcnt_q  <= '0;
               end
            end
            KG_START: begin
               if (!key_s) begin
                  state_q <= KG_IDLE;
               end else if (dcnt_q == OPEN_LAST) begin
                  state_q <= KG_ON;
               end else begin
                  dcnt_q <= dcnt_q + 1'b1;
               end
            end
            KG_ON: begin
               if (!key_s) begin
                  state_q <= KG_STOP;
                  dcnt_q  <= '0;
               end
            end
            KG_STOP: begin
               if (key_s) begin
                  state_q <= KG_ON;
               end else if (dcnt_q == CLOSE_LAST) begin
                  state_q <= KG_IDLE;
               end else begin
                  dcnt_q <= dcnt_q + 1'b1;
               end
            end
            default: state_q <= KG_IDLE;
         endcase
      end
   end

   assign gate_o = (state_q == KG_ON) || (state_q == KG_STOP);

   // R5: the gate opens only after a complete half-period wait
   p_open_after_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_o) |-> ($past(state_q) == KG_START && $past(dcnt_q) == OPEN_LAST));

   // R6: the gate closes only from the hold state at the end of its count
   p_close_after_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gate_o) |-> ($past(state_q) == KG_STOP && $past(dcnt_q) == CLOSE_LAST));

   // R7: a key that drops during the opening wait never opens the gate
   p_short_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == KG_START && !key_s) |=> !gate_o);

   // R8: a re-rise during the hold keeps the gate open
   p_rekey_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == KG_STOP && key_s) |=> gate_o);

endmodule

// File: rtl/tgen_divider.sv
module tgen_divider #(
   parameter int HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic go_i,
   output logic tone_o
);

   localparam int CW = $clog2(HALF);
   localparam logic [CW-1:0] LAST = CW'(HALF - 1);

   if (HALF < 2) begin : g_bad_half
      $error("tgen_divider: HALF must be at least 2");
   end

   logic          tone_q;
   logic          run_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tone_q <= 1'b0;
         run_q  <= 1'b0;
         cnt_q  <= '0;
      end else if (!arm_i) begin
         tone_q <= 1'b0;
         run_q  <= 1'b0;
         cnt_q  <= '0;
      end else if (!run_q) begin
         if (go_i) begin
            run_q  <= 1'b1;
            tone_q <= 1'b1;
            cnt_q  <= '0;
         end
      end else if (tone_q) begin
         // a high segment always completes
         if (cnt_q == LAST) begin
            cnt_q  <= '0;
            tone_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end else begin
         if (!go_i) begin
            run_q <= 1'b0;
            cnt_q <= '0;
         end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            tone_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign tone_o = tone_q;

   // R10: a high segment is never cut short while armed
   p_full_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_i && tone_q && cnt_q != LAST) |=> tone_q);

   // R9: disarming clears the tone register
   p_low_disarmed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !arm_i |=> !tone_q);

   // R3: the segment counter stays inside one half-period
   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

endmodule

// File: rtl/tone_gate_keyer.sv
module tone_gate_keyer #(
   parameter int CLK_HZ      = 125_000_000,
   parameter int TONE_HZ     = 22_000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_arm,
   input  logic cont_en,
   input  logic key_in,
   output logic tone_out,
   output logic stage_on
);

   localparam int HALF = tgen_pkg::half_cycles(CLK_HZ, TONE_HZ);

   if (2 * TONE_HZ > CLK_HZ) begin : g_bad_ratio
      $error("tone_gate_keyer: clock too slow for the tone");
   end

   logic arm_q;
   logic key_s;
   logic key_gate;
   logic go;
   logic tone_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) arm_q <= 1'b0;
      else        arm_q <= tx_arm;
   end

   tgen_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (key_in),
      .q_o   (key_s)
   );

   tgen_keygate #(.HALF(HALF)) u_keygate (
      .clk    (clk),
      .rst_n  (rst_n),
      .key_s  (key_s),
      .gate_o (key_gate)
   );

   assign go = arm_q & (cont_en | key_gate);

   tgen_divider #(.HALF(HALF)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm_i  (arm_q),
      .go_i   (go),
      .tone_o (tone_raw)
   );

   assign tone_out = tone_raw & arm_q;
   assign stage_on = arm_q;

   // R2: the stage indication follows the arming input by one edge
   p_stage_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (stage_on == $past(tx_arm)));

   // R9: a disarmed stage starts no tone on the next edge
   p_no_start_disarmed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!stage_on && !tone_out) |=> !$rose(tone_raw));

endmodule

// File: tb/tone_gate_keyer_tb.sv
module tone_gate_keyer_tb;

   localparam int CLK_HZ  = 100;
   localparam int TONE_HZ = 10;
   localparam int H       = (CLK_HZ + TONE_HZ) / (2 * TONE_HZ);  // 5

   logic clk = 1'b0;
   logic rst_n, tx_arm, cont_en, key_in;
   logic tone_out, stage_on;
   int   vec = 0;
   int   bad = 0;

   always #4 clk = ~clk;   // 125 MHz

   tone_gate_keyer #(.CLK_HZ(CLK_HZ), .TONE_HZ(TONE_HZ), .SYNC_STAGES(2)) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .tx_arm   (tx_arm),
      .cont_en  (cont_en),
      .key_in   (key_in),
      .tone_out (tone_out),
      .stage_on (stage_on)
   );

   // expected tone after edge n: starts high at t0, go withdrawn from edge g
   function automatic logic tone_exp(input int n, input int t0, input int g);
      int s;
      if (n < t0) return 1'b0;
      if (n < g) return (((n - t0) / H) % 2) == 0;
      if (g - 1 < t0) return 1'b0;
      s = (g - 1 - t0) / H;
      return ((s % 2) == 0) && (n < t0 + (s + 1) * H);
   endfunction

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input logic act, input logic exp, input string req,
                      input string what, input int n);
      vec++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s cycle %0d actual %b expected %b", req, what, n, act, exp);
      end
   endtask

   task automatic quiet(input int k);
      key_in  = 1'b0;
      cont_en = 1'b0;
      repeat (k) tick();
   endtask

   // one or two keying pulses, key sampled high from relative edge 1
   task automatic keyed_run(input int l1, input int gap, input int l2);
      int f, t0, g, total;
      bit none;
      f     = (l2 > 0) ? l1 + gap + l2 + 1 : l1 + 1;
      t0    = 4 + H;
      g     = f + 3 + 2 * H;
      none  = (l1 <= H) && (l2 == 0);
      total = f + 4 * H + 10;
      for (int i = 1; i <= total; i++) begin
         key_in = (i <= l1) || (l2 > 0 && i > l1 + gap && i <= l1 + gap + l2);
         tick();
         if (none)
            chk(tone_out, 1'b0, "R7", "tone", i);
         else if (l2 > 0)
            chk(tone_out, tone_exp(i, t0, g), "R8", "tone", i);
         else if (i < t0)
            chk(tone_out, tone_exp(i, t0, g), "R5", "tone", i);
         else if (i < g)
            chk(tone_out, tone_exp(i, t0, g), "R3", "tone", i);
         else
            chk(tone_out, tone_exp(i, t0, g), "R6", "tone", i);
      end
      chk(stage_on, 1'b1, "R2", "stage", total);
      quiet(4 * H);
   endtask

   // continuous tone for on_len edges, with a short key pulse inside
   task automatic cont_run(input int on_len, input int keylen);
      int g;
      g = on_len + 1;
      for (int i = 1; i <= on_len + 3 * H; i++) begin
         cont_en = (i <= on_len);
         key_in  = (i > 2) && (i <= 2 + keylen);
         tick();
         if (i < g)
            chk(tone_out, tone_exp(i, 1, g), "R4", "tone", i);
         else
            chk(tone_out, tone_exp(i, 1, g), "R10", "tone", i);
      end
      quiet(4 * H);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

   initial begin : main
      int d;
      rst_n   = 1'b0;
      tx_arm  = 1'b1;
      cont_en = 1'b1;
      key_in  = 1'b1;
      repeat (3) tick();
      chk(tone_out, 1'b0, "R1", "tone in reset", 0);
      chk(stage_on, 1'b0, "R1", "stage in reset", 0);
      cont_en = 1'b0;
      key_in  = 1'b0;
      tx_arm  = 1'b0;
      rst_n   = 1'b1;
      tick();
      chk(tone_out, 1'b0, "R1", "tone after reset", 1);
      chk(stage_on, 1'b0, "R1", "stage after reset", 1);

      // arm and check the stage indication
      tx_arm = 1'b1;
      tick();
      chk(stage_on, 1'b1, "R2", "stage", 1);
      quiet(4 * H);

      // keyed: every pulse length from far too short to several periods
      for (int l = 1; l <= 4 * H; l++) keyed_run(l, 0, 0);

      // keyed: re-key within the close delay merges the burst
      for (int l = H + 1; l <= 2 * H; l += H - 1)
         for (int gp = 1; gp <= 2 * H; gp += (gp == 1) ? H - 1 : H)
            for (int l2 = 1; l2 <= 3; l2 += 2) keyed_run(l, gp, l2);

      // continuous: stop requested in every phase of the tone
      for (int on = 1; on <= 3 * H; on++) cont_run(on, H);

      // disarmed: nothing reaches the output
      tx_arm = 1'b0;
      tick();
      chk(stage_on, 1'b0, "R2", "stage", 0);
      cont_en = 1'b1;
      for (int i = 1; i <= 30; i++) begin
         key_in = (i <= 20);
         tick();
         chk(tone_out, 1'b0, "R9", "tone", i);
         chk(stage_on, 1'b0, "R9", "stage", i);
      end
      key_in = 1'b0;
      repeat (4 * H) tick();

      // arm with continuous mode already on, then disarm mid-high
      d = 2 + 2 * H + 2;
      for (int i = 1; i <= d + 2 * H; i++) begin
         tx_arm = (i < d);
         tick();
         chk(stage_on, logic'(i < d), "R2", "stage", i);
         chk(tone_out, (i < d) ? tone_exp(i, 2, 1000000) : 1'b0, "R9", "tone", i);
      end
      cont_en = 1'b0;
      tx_arm  = 1'b1;
      repeat (2 * H) tick();

      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

endmodule